// File: doc/BRIEF.md
# Accelerated Span-Fill Writer for Video Memory

This block sits between a processor byte-write bus and the byte-wide write port of a frame buffer. A small register window picks a fill mode. From then on every processor write becomes a run of identical bytes written to video memory. The length and alignment of that run depend on the active mode and on the target address. The rules snap to 4-byte quads, or to 20-byte groups counted from the start of the 1024-byte line that holds the target.

For each accepted write, the block works out the first and last address of the span. It then issues one memory write per clock, in ascending address order, and holds `busy` high while the run lasts. A processor write presented while `busy` is high is stalled and is taken once the run ends. Processor reads do not pass through the fill engine: the read address goes straight to the memory and the read data comes straight back. Any span that would pass the top of memory is cut short at the last valid address.

Top module: `vram_span_fill`

## Requirements
- R1: A pulse on `mode_we` loads the mode register with `mode_ofs[4:1]`. Bit 0 of the offset has no effect. The new mode applies to writes accepted after the loading edge.
- R2: Reset clears the mode register to 0 and clears `busy`, `mem_we` and `unsup_mode`. After reset, a write with no mode load in between performs a single-byte write.
- R3: Mode 0 writes the data byte once, at the target address.
- R4: Mode 1 writes the byte to the target address and to the three addresses that follow it.
- R5: Mode 2 writes every address from the target rounded down to a multiple of 4 through the target itself, inclusive.
- R6: Mode 3 writes every address from the target up to the next multiple of 4 strictly above it. That multiple of 4 is not written.
- R7: Mode 5 writes 20 consecutive addresses, starting at the target.
- R8: Mode 9 starts at the first byte of the target's 20-byte group. Groups are counted from the start of the target's 1024-byte line. The fill stops before (target+4) with its two low bits cleared.
- R9: Mode 13 writes from the target up to the next 20-byte group boundary of its 1024-byte line. The boundary itself is not written. The span may run on into the next line.
- R10: Mode values 4, 6, 7, 8, 10, 11, 12, 14 and 15 give a single-byte write at the target. `unsup_mode` is high while the mode register holds one of them.
- R11: The first write of a span appears on the cycle after the accepting edge. Each following cycle writes the next higher address with the same data. `busy` is high exactly while the run is issuing writes. A write request held during `busy` is accepted on the first edge at which `busy` is low, so there is one idle cycle between runs.
- R12: No write goes to an address at or above `MEM_BYTES` (0x78000). A span that crosses that limit ends at 0x77FFF. A target at or above the limit produces no write and does not raise `busy`.
- R13: `mem_raddr` follows `rd_addr`, and `rd_data` follows `mem_rdata`, combinationally and in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the mode register window |
| mode_ofs | input | 5 | Byte offset within the mode window; bits 4:1 give the mode |
| wr_req | input | 1 | Processor write request to video memory |
| wr_addr | input | 19 | Processor write target address |
| wr_data | input | 8 | Processor write data byte |
| rd_addr | input | 19 | Processor read address |
| rd_data | output | 8 | Processor read data |
| busy | output | 1 | Span run in progress; processor writes stall |
| unsup_mode | output | 1 | Mode register holds a value with no fill rule |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 19 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_raddr | output | 19 | Memory read address |
| mem_rdata | input | 8 | Memory read data |

## Verification
For a write accepted at a clock edge, the first memory write is due one cycle later. The k-th byte of the span is due k cycles after that. `busy` and `mem_we` fall one cycle after the last write, and a held request starts its own run one cycle after that. The bench drives inputs on the falling edge and samples on the next falling edge, so each read lands in the middle of the cycle it targets. It walks the span cycle by cycle against a first address and length worked out by hand. `unsup_mode` is read one cycle after a mode load. Read pass-through is combinational, so it is checked a moment after the address changes.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

   typedef logic [3:0] mode_t;

   localparam mode_t MD_SINGLE = 4'd0;
   localparam mode_t MD_QUAD   = 4'd1;
   localparam mode_t MD_QTAIL  = 4'd2;
   localparam mode_t MD_QHEAD  = 4'd3;
   localparam mode_t MD_RUN    = 4'd5;
   localparam mode_t MD_GTAIL  = 4'd9;
   localparam mode_t MD_GHEAD  = 4'd13;

   function automatic logic mode_known(mode_t m);
      case (m)
         MD_SINGLE, MD_QUAD, MD_QTAIL, MD_QHEAD,
         MD_RUN, MD_GTAIL, MD_GHEAD: mode_known = 1'b1;
         default:                    mode_known = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/vsf_mode_reg.sv
module vsf_mode_reg
   import vsf_pkg::*;
#(
   parameter int WIN_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [WIN_AW-1:0] mode_ofs,
   output mode_t             mode_q,
   output logic              unsup
);

   logic unused_ofs_lsb;
   assign unused_ofs_lsb = mode_ofs[0];

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= MD_SINGLE;
      else if (mode_we) mode_q <= mode_ofs[WIN_AW-1:1];
   end

   assign unsup = !mode_known(mode_q);

   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> (mode_q == $past(mode_ofs[WIN_AW-1:1]))); // R1

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_we && $past(rst_n)) |=> $stable(mode_q)); // R1

endmodule

// File: rtl/vsf_span_calc.sv
module vsf_span_calc
   import vsf_pkg::*;
#(
   parameter int AW          = 19,
   parameter int MEM_BYTES   = 32'h78000,
   parameter int LINE_BYTES  = 1024,
   parameter int GROUP_BYTES = 20,
   parameter int QUAD_BYTES  = 4,
   parameter bit CLIP_EN     = 1'b1
) (
   input  mode_t          mode,
   input  logic [AW-1:0]  target,
   output logic [AW-1:0]  span_first,
   output logic [AW-1:0]  span_last,
   output logic           span_ok
);

   localparam int XW = AW + 1;
   localparam logic [XW-1:0] LINE_X = XW'(LINE_BYTES);
   localparam logic [XW-1:0] GRP_X  = XW'(GROUP_BYTES);
   localparam logic [XW-1:0] QUAD_X = XW'(QUAD_BYTES);
   localparam logic [XW-1:0] QMASK  = ~XW'(QUAD_BYTES - 1);
   localparam logic [XW-1:0] MEM_X  = XW'(MEM_BYTES);
   localparam logic [XW-1:0] ONE_X  = XW'(1);

   logic [XW-1:0] t_x, col, gofs, qdown, qup, s_x, e_x, e_c;

   always_comb begin
      t_x   = {1'b0, target};
      col   = t_x % LINE_X;
      gofs  = col % GRP_X;
      qdown = t_x & QMASK;
      qup   = (t_x + QUAD_X) & QMASK;
      case (mode)
         MD_QUAD:  begin s_x = t_x;        e_x = t_x + QUAD_X;         end
         MD_QTAIL: begin s_x = qdown;      e_x = t_x + ONE_X;          end
         MD_QHEAD: begin s_x = t_x;        e_x = qup;                  end
         MD_RUN:   begin s_x = t_x;        e_x = t_x + GRP_X;          end
         MD_GTAIL: begin s_x = t_x - gofs; e_x = qup;                  end
         MD_GHEAD: begin s_x = t_x;        e_x = t_x + GRP_X - gofs;   end
         default:  begin s_x = t_x;        e_x = t_x + ONE_X;          end
      endcase
   end

   generate
      if (CLIP_EN) begin : g_clip
         assign e_c = (e_x > MEM_X) ? MEM_X : e_x;
      end else begin : g_noclip
         assign e_c = e_x;
      end
   endgenerate

   assign span_ok    = (s_x < e_c) && (s_x < MEM_X);
   assign span_first = s_x[AW-1:0];
   assign span_last  = AW'(e_c - ONE_X);

endmodule

// File: rtl/vsf_fill_seq.sv
module vsf_fill_seq #(
   parameter int AW = 19,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_first,
   input  logic [AW-1:0] ld_last,
   input  logic [DW-1:0] ld_data,
   output logic          busy,
   output logic          we,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata
);

   logic          run_q;
   logic [AW-1:0] cur_q, last_q;
   logic [DW-1:0] dat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cur_q  <= '0;
         last_q <= '0;
         dat_q  <= '0;
      end else if (load) begin
         run_q  <= 1'b1;
         cur_q  <= ld_first;
         last_q <= ld_last;
         dat_q  <= ld_data;
      end else if (run_q) begin
         if (cur_q == last_q) run_q <= 1'b0;
         else                 cur_q <= cur_q + 1'b1;
      end
   end

   assign busy  = run_q;
   assign we    = run_q;
   assign addr  = cur_q;
   assign wdata = dat_q;

   AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !run_q); // R11

   AST_ADDR_ASC: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && (cur_q != last_q)) |=> (run_q && (cur_q == $past(cur_q) + 1'b1))); // R11

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && (cur_q != last_q)) |=> $stable(dat_q)); // R11

endmodule

// File: rtl/vram_span_fill.sv
module vram_span_fill
   import vsf_pkg::*;
#(
   parameter int AW          = 19,
   parameter int DW          = 8,
   parameter int WIN_AW      = 5,
   parameter int MEM_BYTES   = 32'h78000,
   parameter int LINE_BYTES  = 1024,
   parameter int GROUP_BYTES = 20,
   parameter int QUAD_BYTES  = 4,
   parameter bit CLIP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [WIN_AW-1:0] mode_ofs,
   input  logic              wr_req,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              busy,
   output logic              unsup_mode,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [AW-1:0]     mem_raddr,
   input  logic [DW-1:0]     mem_rdata
);

   localparam logic [AW:0] MEM_X = (AW+1)'(MEM_BYTES);

   generate
      if (WIN_AW - 1 != $bits(mode_t)) begin : g_bad_win
         $error("mode window offset must carry exactly one mode field");
      end
      if (MEM_BYTES > (1 << AW)) begin : g_bad_mem
         $error("memory size exceeds address range");
      end
      if ((QUAD_BYTES & (QUAD_BYTES - 1)) != 0) begin : g_bad_quad
         $error("quad size must be a power of two");
      end
      if (GROUP_BYTES < QUAD_BYTES || LINE_BYTES < GROUP_BYTES) begin : g_bad_grp
         $error("group and line sizes out of order");
      end
   endgenerate

   mode_t         mode_q;
   logic [AW-1:0] span_first, span_last;
   logic          span_ok, accept;

   vsf_mode_reg #(.WIN_AW(WIN_AW)) i_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (mode_we),
      .mode_ofs (mode_ofs),
      .mode_q   (mode_q),
      .unsup    (unsup_mode)
   );

   vsf_span_calc #(
      .AW(AW), .MEM_BYTES(MEM_BYTES), .LINE_BYTES(LINE_BYTES),
      .GROUP_BYTES(GROUP_BYTES), .QUAD_BYTES(QUAD_BYTES), .CLIP_EN(CLIP_EN)
   ) i_calc (
      .mode       (mode_q),
      .target     (wr_addr),
      .span_first (span_first),
      .span_last  (span_last),
      .span_ok    (span_ok)
   );

   assign accept = wr_req && !busy && span_ok;

   vsf_fill_seq #(.AW(AW), .DW(DW)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .ld_first (span_first),
      .ld_last  (span_last),
      .ld_data  (wr_data),
      .busy     (busy),
      .we       (mem_we),
      .addr     (mem_addr),
      .wdata    (mem_wdata)
   );

   assign mem_raddr = rd_addr;
   assign rd_data   = mem_rdata;

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ({1'b0, mem_addr} < MEM_X)); // R12

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !busy && mode_q == MD_SINGLE && ({1'b0, wr_addr} < MEM_X))
      |=> (mem_we && mem_addr == $past(wr_addr) && mem_wdata == $past(wr_data))
      ##1 !mem_we); // R3

   AST_UNSUP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !busy && unsup_mode && ({1'b0, wr_addr} < MEM_X))
      |=> (mem_we && mem_addr == $past(wr_addr)) ##1 !mem_we); // R10

   AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !busy && ({1'b0, wr_addr} >= MEM_X)) |=> !mem_we); // R12

endmodule

// File: tb/test_vram_span_fill.sv
module test_vram_span_fill;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode_we;
   logic [4:0]  mode_ofs;
   logic        wr_req;
   logic [18:0] wr_addr;
   logic [7:0]  wr_data;
   logic [18:0] rd_addr;
   logic [7:0]  rd_data;
   logic        busy, unsup_mode, mem_we;
   logic [18:0] mem_addr, mem_raddr;
   logic [7:0]  mem_wdata, mem_rdata;

   always #10 clk = ~clk;

   vram_span_fill i_vram_span_fill (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_ofs(mode_ofs),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .unsup_mode(unsup_mode),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] model [int];

   typedef struct packed {
      logic [4:0]  ofs;
      logic [18:0] addr;
      logic [7:0]  data;
      logic [18:0] st;
      logic [5:0]  len;
      logic        unsup;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VT [NV] = '{
      '{5'h00, 19'h00105, 8'hA1, 19'h00105, 6'd1,  1'b0, 4'd3},  // R3
      '{5'h02, 19'h00102, 8'hB2, 19'h00102, 6'd4,  1'b0, 4'd4},  // R4
      '{5'h05, 19'h00107, 8'hC3, 19'h00104, 6'd4,  1'b0, 4'd5},  // R5, offset bit0 set
      '{5'h04, 19'h00108, 8'hC4, 19'h00108, 6'd1,  1'b0, 4'd5},  // R5
      '{5'h06, 19'h00105, 8'hD5, 19'h00105, 6'd3,  1'b0, 4'd6},  // R6
      '{5'h07, 19'h00104, 8'hD6, 19'h00104, 6'd4,  1'b0, 4'd6},  // R6
      '{5'h0A, 19'h00203, 8'hE7, 19'h00203, 6'd20, 1'b0, 4'd7},  // R7
      '{5'h12, 19'h0042D, 8'h18, 19'h00428, 6'd8,  1'b0, 4'd8},  // R8
      '{5'h13, 19'h00816, 8'h29, 19'h00814, 6'd4,  1'b0, 4'd8},  // R8
      '{5'h12, 19'h003FD, 8'h3A, 19'h003FC, 6'd4,  1'b0, 4'd8},  // R8
      '{5'h1A, 19'h0042D, 8'h4B, 19'h0042D, 6'd15, 1'b0, 4'd9},  // R9
      '{5'h1B, 19'h003FD, 8'h5C, 19'h003FD, 6'd19, 1'b0, 4'd9},  // R9 crosses line
      '{5'h1A, 19'h00428, 8'h6D, 19'h00428, 6'd20, 1'b0, 4'd9},  // R9
      '{5'h08, 19'h00300, 8'h7E, 19'h00300, 6'd1,  1'b1, 4'd10}, // R10 mode 4
      '{5'h1E, 19'h00301, 8'h8F, 19'h00301, 6'd1,  1'b1, 4'd10}, // R10 mode 15
      '{5'h0C, 19'h00302, 8'h90, 19'h00302, 6'd1,  1'b1, 4'd10}, // R10 mode 6
      '{5'h0A, 19'h77FF8, 8'hA2, 19'h77FF8, 6'd8,  1'b0, 4'd12}, // R12 clipped
      '{5'h00, 19'h78010, 8'hB3, 19'h78010, 6'd0,  1'b0, 4'd12}  // R12 dropped
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_mode(input logic [4:0] ofs);
      mode_we  = 1'b1;
      mode_ofs = ofs;
      @(negedge clk);
      mode_we  = 1'b0;
   endtask

   // called at a falling edge with busy low
   task automatic run_span(input logic [18:0] a, input logic [7:0] d,
                           input logic [18:0] st, input int len, input string req);
      wr_req  = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_req = 1'b0;
      for (int k = 0; k < len; k++) begin
         chk(mem_we && busy, req, "write enable", {busy, mem_we}, 3);
         chk(mem_addr == st + 19'(k), req, "write address", mem_addr, st + 19'(k));
         chk(mem_wdata == d, req, "write data", mem_wdata, d);
         model[int'(mem_addr)] = mem_wdata;
         @(negedge clk);
      end
      chk(!mem_we && !busy, req, "idle after span", {busy, mem_we}, 0);
   endtask

   task automatic finish_up;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      rst_n = 1'b0; mode_we = 1'b0; mode_ofs = '0; wr_req = 1'b0;
      wr_addr = '0; wr_data = '0; rd_addr = '0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state and default single write
      chk(!busy && !mem_we && !unsup_mode, "R2", "reset outputs",
          {busy, mem_we, unsup_mode}, 0);
      run_span(19'h00010, 8'h5A, 19'h00010, 1, "R2");

      // vector table walk (R1 via the mode offset of each vector)
      for (int i = 0; i < NV; i++) begin
         set_mode(VT[i].ofs);
         chk(unsup_mode == VT[i].unsup, $sformatf("R%0d", VT[i].req), "unsupported flag",
             unsup_mode, VT[i].unsup);
         run_span(VT[i].addr, VT[i].data, VT[i].st, int'(VT[i].len),
                  $sformatf("R%0d", VT[i].req));
      end

      // R11: stall of a held request, mode change during a run (R1)
      set_mode(5'h02);
      wr_req = 1'b1; wr_addr = 19'h00500; wr_data = 8'h11;
      @(negedge clk);
      wr_addr = 19'h00600; wr_data = 8'h22;
      mode_we = 1'b1; mode_ofs = 5'h00;
      for (int k = 0; k < 4; k++) begin
         chk(mem_we && busy && mem_addr == 19'h00500 + 19'(k) && mem_wdata == 8'h11,
             "R11", "stalled run address", mem_addr, 19'h00500 + 19'(k));
         @(negedge clk);
         mode_we = 1'b0;
      end
      chk(!mem_we && !busy, "R11", "gap cycle", {busy, mem_we}, 0);
      @(negedge clk);
      wr_req = 1'b0;
      chk(mem_we && mem_addr == 19'h00600 && mem_wdata == 8'h22, "R11",
          "held request served in new mode", mem_addr, 19'h00600);
      @(negedge clk);
      chk(!mem_we && !busy, "R1", "mode 0 single after change", {busy, mem_we}, 0);

      // R13: read pass-through
      rd_addr = 19'h0042A;
      mem_rdata = model[32'h42A];
      #1;
      chk(mem_raddr == 19'h0042A, "R13", "read address", mem_raddr, 19'h0042A);
      chk(rd_data == 8'h6D, "R13", "read data", rd_data, 8'h6D);
      rd_addr = 19'h77FFF;
      mem_rdata = model[32'h77FFF];
      #1;
      chk(mem_raddr == 19'h77FFF && rd_data == 8'hA2, "R13", "read data top",
          rd_data, 8'hA2);

      // R2: reset returns mode to 0
      @(negedge clk);
      set_mode(5'h1E);
      chk(unsup_mode, "R10", "flag set before reset", unsup_mode, 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!unsup_mode && !busy, "R2", "flag cleared by reset", unsup_mode, 0);
      run_span(19'h00777, 8'hEE, 19'h00777, 1, "R2");

      finish_up();
   end

endmodule